// File: doc/BRIEF.md
# Input Edge Time-Stamp Timer

This block is a free-running counter that stamps the moment a chosen transition appears on an asynchronous input pin. The counter is 16 bits wide on its own and becomes 24 bits wide when the 8-bit prescale extension is switched on. It counts up or down and keeps counting through every capture. When a qualified transition arrives, the running count is copied into a capture register. At the same time a sticky event flag is raised, and an optional single-cycle pulse is sent to a DMA request line.

The input first passes through a two-flop synchroniser. It then goes to a four-state qualifier: LOW (stable low), RISE_CHK (a high level seen once), HIGH (stable high) and FALL_CHK (a low level seen once). The transitions are:
- LOW→RISE_CHK when the synchronised level is 1.
- RISE_CHK→HIGH when it is still 1. This emits a rise event.
- RISE_CHK→LOW when it has dropped back to 0. The glitch is rejected.
- HIGH→FALL_CHK when the level is 0.
- FALL_CHK→LOW when it is still 0. This emits a fall event.
- FALL_CHK→HIGH when it is back to 1. The glitch is rejected.
- Any other case holds the current state.

Software drives the block through a flat register interface with one write port and a combinational read port.

Top module: `edge_stamp_timer`

## Requirements
- R1: A transition is qualified only if the synchronised input shows the new level on two consecutive clock samples. A pin change held for a single clock is ignored. When the pin changes just before clock edge P and then holds, the capture register takes the counter value that was present after edge P+2.
- R2: The event-select field CTRL[4:3] picks which transitions are captured: 0 = rising only, 1 = falling only, 2 or 3 = both.
- R3: A write to CTRL (address 0) that sets bit 0 (run) while the block is stopped loads both the counter and the capture register. The load value depends on the bits written in the same word:
  - Down count (CTRL[1] = 0) with prescale on (CTRL[2] = 1): {PRESCALE[7:0], INTERVAL[15:0]}.
  - Down count with prescale off: INTERVAL alone.
  - Up count (CTRL[1] = 1): zero.
- R4: The capture register (address 5) holds its value until the next qualified, selected transition overwrites it.
- R5: A capture sets the raw flag (STATUS bit 0, address 7). The flag is cleared by writing 1 to bit 0 of address 4. If a capture and that clear land on the same edge, the flag ends up set.
- R6: The masked status (STATUS bit 1) and the `irq` output equal the raw flag ANDed with MASK bit 0 (address 3).
- R7: While run is set, the counter steps on every clock, regardless of captures. While run is clear, the counter holds and no capture occurs.
- R8: On timeout the counter reloads:
  - Counting up, it returns to 0 after the top of its range.
  - Counting down, after 0 it reloads the value given in R3.
- R9: With prescale on, the count wraps modulo 2^24. With it off, the count wraps modulo 2^16 and the upper 8 bits read as zero.
- R10: The live counter value can be read at address 6 at any time, with the prescale bits in [23:16].
- R11: When CTRL[5] is set, each capture raises `dma_trig` for exactly one cycle, in the same cycle the new capture value becomes visible. When CTRL[5] is clear, no pulse is raised.
- R12: After reset, every readable register reads zero, and both `irq` and `dma_trig` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Asynchronous event pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked capture interrupt |
| dma_trig | output | 1 | One-cycle DMA request pulse |

## Verification
Two functions can fall on the same edge: setting the raw flag on a qualified capture, and the software write-one-to-clear of that flag.

The bench provokes the overlap by counting edges from the pin change. It issues the clear write so that its strobe is sampled on exactly the edge where the capture lands. It then reads STATUS and judges the flag correct only if it is still set.

A second overlap is also covered: down-count reload coinciding with a capture window. The bench uses a short interval so that reloads occur inside the stamped window, and compares the stamp against the arithmetic expected value.

// File: rtl/est_pkg.sv
package est_pkg;

    typedef enum logic [1:0] {
        QS_LOW,
        QS_RISE_CHK,
        QS_HIGH,
        QS_FALL_CHK
    } qual_state_t;

    typedef enum logic [1:0] {
        SEL_RISE     = 2'd0,
        SEL_FALL     = 2'd1,
        SEL_BOTH     = 2'd2,
        SEL_BOTH_ALT = 2'd3
    } edge_sel_t;

    localparam logic [2:0] A_CTRL     = 3'd0;
    localparam logic [2:0] A_INTERVAL = 3'd1;
    localparam logic [2:0] A_PRESCALE = 3'd2;
    localparam logic [2:0] A_MASK     = 3'd3;
    localparam logic [2:0] A_CLEAR    = 3'd4;
    localparam logic [2:0] A_CAPTURE  = 3'd5;
    localparam logic [2:0] A_LIVE     = 3'd6;
    localparam logic [2:0] A_STATUS   = 3'd7;

endpackage

// File: rtl/est_edge_qual.sv
module est_edge_qual
    import est_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   lvl;
    qual_state_t            state_q, state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign lvl = chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= QS_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_LOW:      if (lvl)  state_d = QS_RISE_CHK;
            QS_RISE_CHK: state_d = lvl ? QS_HIGH : QS_LOW;
            QS_HIGH:     if (!lvl) state_d = QS_FALL_CHK;
            QS_FALL_CHK: state_d = lvl ? QS_HIGH : QS_LOW;
            default:     state_d = QS_LOW;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            QS_RISE_CHK: rise = lvl;
            QS_FALL_CHK: fall = !lvl;
            default: ;
        endcase
    end

    AST_RISE_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (lvl && $past(lvl))); // R1
    AST_FALL_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (!lvl && !$past(lvl))); // R1
    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !fall); // R1

endmodule

// File: rtl/est_counter.sv
module est_counter #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   load,
    input  logic [CNT_W+PRE_W-1:0] load_val,
    input  logic                   count_up,
    input  logic                   pre_en,
    input  logic [CNT_W+PRE_W-1:0] reload_val,
    output logic [CNT_W+PRE_W-1:0] value
);

    localparam int W = CNT_W + PRE_W;
    localparam logic [W-1:0] FULL_MASK   = {W{1'b1}};
    localparam logic [W-1:0] NARROW_MASK = {{PRE_W{1'b0}}, {CNT_W{1'b1}}};

    logic [W-1:0] mask;
    logic [W-1:0] cur;
    logic [W-1:0] next_val;

    assign mask = pre_en ? FULL_MASK : NARROW_MASK;
    assign cur  = value & mask;

    always_comb begin
        if (count_up)          next_val = (cur + 1'b1) & mask;
        else if (cur == '0)    next_val = reload_val;
        else                   next_val = cur - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (run)  value <= next_val;
    end

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(value)); // R7
    AST_CNT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !pre_en) |=> (value[W-1:CNT_W] == '0)); // R9
    AST_CNT_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && count_up && value == mask) |=> (value == '0)); // R8
    AST_CNT_DN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !count_up && cur == '0) |=> (value == $past(reload_val))); // R8

endmodule

// File: rtl/est_event_status.sv
module est_event_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic clr,
    input  logic mask,
    input  logic dma_en,
    output logic raw,
    output logic masked,
    output logic dma_trig
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw      <= 1'b0;
            dma_trig <= 1'b0;
        end else begin
            if (cap)      raw <= 1'b1;
            else if (clr) raw <= 1'b0;
            dma_trig <= cap && dma_en;
        end
    end

    assign masked = raw && mask;

    AST_RAW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> raw); // R5
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr) |=> raw); // R5
    AST_DMA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_trig |-> $past(cap && dma_en)); // R11

endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer
    import est_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              dma_trig
);

    localparam int W = CNT_W + PRE_W;

    logic             run_q, up_q, pre_q, dma_en_q, mask_q;
    edge_sel_t        sel_q;
    logic [CNT_W-1:0] interval_q;
    logic [PRE_W-1:0] prescale_q;
    logic [W-1:0]     capture_q;
    logic [W-1:0]     live;
    logic [W-1:0]     reload_val, load_val;
    logic             load, clr, cap, rise, fall, raw, masked;
    logic             unused_hi;

    assign unused_hi = &{1'b0, wr_data[DATA_W-1:CNT_W]};

    assign load = wr_en && (wr_addr == A_CTRL) && wr_data[0] && !run_q;
    assign clr  = wr_en && (wr_addr == A_CLEAR) && wr_data[0];

    assign reload_val = pre_q ? {prescale_q, interval_q} : {{PRE_W{1'b0}}, interval_q};
    assign load_val   = wr_data[1] ? '0 :
                        (wr_data[2] ? {prescale_q, interval_q} : {{PRE_W{1'b0}}, interval_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            up_q       <= 1'b0;
            pre_q      <= 1'b0;
            sel_q      <= SEL_RISE;
            dma_en_q   <= 1'b0;
            mask_q     <= 1'b0;
            interval_q <= '0;
            prescale_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    run_q    <= wr_data[0];
                    up_q     <= wr_data[1];
                    pre_q    <= wr_data[2];
                    sel_q    <= edge_sel_t'(wr_data[4:3]);
                    dma_en_q <= wr_data[5];
                end
                A_INTERVAL: interval_q <= wr_data[CNT_W-1:0];
                A_PRESCALE: prescale_q <= wr_data[PRE_W-1:0];
                A_MASK:     mask_q     <= wr_data[0];
                default: ;
            endcase
        end
    end

    est_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (evt_in),
        .rise (rise),
        .fall (fall)
    );

    always_comb begin
        unique case (sel_q)
            SEL_RISE: cap = run_q && rise;
            SEL_FALL: cap = run_q && fall;
            default:  cap = run_q && (rise || fall);
        endcase
    end

    est_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .load      (load),
        .load_val  (load_val),
        .count_up  (up_q),
        .pre_en    (pre_q),
        .reload_val(reload_val),
        .value     (live)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    capture_q <= '0;
        else if (load) capture_q <= load_val;
        else if (cap)  capture_q <= live;
    end

    est_event_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .clr     (clr),
        .mask    (mask_q),
        .dma_en  (dma_en_q),
        .raw     (raw),
        .masked  (masked),
        .dma_trig(dma_trig)
    );

    assign irq = masked;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:     rd_data[5:0] = {dma_en_q, sel_q, pre_q, up_q, run_q};
            A_INTERVAL: rd_data[CNT_W-1:0] = interval_q;
            A_PRESCALE: rd_data[PRE_W-1:0] = prescale_q;
            A_MASK:     rd_data[0] = mask_q;
            A_CAPTURE:  rd_data[W-1:0] = capture_q;
            A_LIVE:     rd_data[W-1:0] = live;
            A_STATUS:   rd_data[1:0] = {masked, raw};
            default: ;
        endcase
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !load) |=> $stable(capture_q)); // R4
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !irq); // R6
    AST_NO_CAPTURE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load) |=> !$changed(capture_q)); // R7

endmodule

// File: tb/test_edge_stamp_timer.sv
`timescale 1ns/1ps
module test_edge_stamp_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, dma_trig;

    int tests = 0;
    int fails = 0;
    int dma_seen = 0;

    always #4 clk = ~clk;

    edge_stamp_timer i_edge_stamp_timer (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .dma_trig(dma_trig)
    );

    always @(negedge clk) if (dma_trig) dma_seen++;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] model(input int k, input bit up, input bit pre,
                                          input logic [15:0] iv, input logic [7:0] ps);
        longint m, l;
        m = pre ? 64'd16777216 : 64'd65536;
        if (up) return 32'(longint'(k) % m);
        l = pre ? longint'({ps, iv}) : longint'(iv);
        return 32'(l - (longint'(k) % (l + 1)));
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, c0;
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        for (int a = 0; a < 8; a++) begin
            do_rd(3'(a), v);
            check($sformatf("R12 reg %0d", a), v, 0);
        end
        check("R12 irq", {31'd0, irq}, 0);
        check("R12 dma_trig", {31'd0, dma_trig}, 0);

        do_wr(3'd1, 32'd3);
        do_wr(3'd2, 32'd2);

        // R2 R3 R4 R8 R10 R11 sweep
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 3; s++) begin
                    logic [31:0] ctl, exp_cap;
                    do_wr(3'd0, 32'd0);
                    do_wr(3'd4, 32'd1);
                    d0 = dma_seen;
                    ctl = 32'(1 | (d << 1) | (p << 2) | (s << 3) | (1 << 5));
                    do_wr(3'd0, ctl);
                    do_rd(3'd5, v);
                    check($sformatf("R3 capture init d%0d p%0d", d, p), v, model(0, d[0], p[0], 16'd3, 8'd2));
                    do_rd(3'd6, v);
                    check($sformatf("R10 live after load d%0d p%0d", d, p), v, model(0, d[0], p[0], 16'd3, 8'd2));
                    repeat (3) @(negedge clk);
                    evt_in = 1'b1;
                    repeat (2) @(negedge clk);
                    evt_in = 1'b0;
                    repeat (8) @(negedge clk);
                    exp_cap = (s == 0) ? model(6, d[0], p[0], 16'd3, 8'd2) : model(8, d[0], p[0], 16'd3, 8'd2);
                    do_rd(3'd5, v);
                    check($sformatf("R2 R4 R8 capture d%0d p%0d s%0d", d, p, s), v, exp_cap);
                    do_rd(3'd7, v);
                    check($sformatf("R5 raw set s%0d", s), v & 32'd1, 1);
                    check($sformatf("R11 dma pulses s%0d", s), 32'(dma_seen - d0), (s == 2) ? 2 : 1);
                end

        // R5 set wins over clear on the same edge
        do_wr(3'd0, 32'd0);
        do_wr(3'd4, 32'd1);
        do_wr(3'd0, 32'h3);
        d0 = dma_seen;
        evt_in = 1'b1;
        repeat (3) @(negedge clk);
        do_wr(3'd4, 32'd1);
        @(negedge clk);
        do_rd(3'd7, v);
        check("R5 set wins over clear", v & 32'd1, 1);
        check("R11 no pulse when gated off", 32'(dma_seen - d0), 0);

        // R6 mask
        check("R6 irq masked off", {31'd0, irq}, 0);
        do_wr(3'd3, 32'd1);
        check("R6 irq unmasked", {31'd0, irq}, 1);
        do_rd(3'd7, v);
        check("R6 masked status", v, 32'd3);
        evt_in = 1'b0;
        repeat (8) @(negedge clk);
        do_wr(3'd4, 32'd1);
        do_rd(3'd7, v);
        check("R5 clear", v, 0);
        check("R6 irq after clear", {31'd0, irq}, 0);
        do_wr(3'd3, 32'd0);

        // R1 rising glitch rejected
        do_wr(3'd0, 32'd0);
        do_wr(3'd0, 32'h1);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
        repeat (8) @(negedge clk);
        do_rd(3'd7, v);
        check("R1 one-cycle high ignored", v & 32'd1, 0);

        // R1 falling glitch rejected (both edges selected)
        do_wr(3'd0, 32'd0);
        do_wr(3'd0, 32'h11);
        evt_in = 1'b1;
        repeat (6) @(negedge clk);
        do_wr(3'd4, 32'd1);
        evt_in = 1'b0;
        @(negedge clk);
        evt_in = 1'b1;
        repeat (8) @(negedge clk);
        do_rd(3'd7, v);
        check("R1 one-cycle low ignored", v & 32'd1, 0);
        evt_in = 1'b0;
        repeat (8) @(negedge clk);

        // R7 no capture while stopped, counter frozen
        do_wr(3'd0, 32'h10);
        do_wr(3'd4, 32'd1);
        do_rd(3'd5, c0);
        evt_in = 1'b1;
        repeat (4) @(negedge clk);
        evt_in = 1'b0;
        repeat (8) @(negedge clk);
        do_rd(3'd7, v);
        check("R7 no flag while stopped", v & 32'd1, 0);
        do_rd(3'd5, v);
        check("R7 capture unchanged while stopped", v, c0);
        do_rd(3'd6, c0);
        repeat (5) @(negedge clk);
        do_rd(3'd6, v);
        check("R7 counter frozen", v, c0);

        // R9 R8 up wrap at 2^16 without prescale
        do_wr(3'd0, 32'h3);
        repeat (65540) @(negedge clk);
        do_rd(3'd6, v);
        check("R9 R8 16-bit wrap", v, model(65540, 1'b1, 1'b0, 16'd3, 8'd2));

        // R9 24-bit range with prescale
        do_wr(3'd0, 32'd0);
        do_wr(3'd0, 32'h7);
        repeat (65540) @(negedge clk);
        do_rd(3'd6, v);
        check("R9 24-bit no wrap", v, model(65540, 1'b1, 1'b1, 16'd3, 8'd2));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule